// File: doc/BRIEF.md
# Packed Programmable Frequency Generator Bank

The block holds six programmable frequency generators whose settings are packed into two 32-bit control words, three generators to a word. Each generator takes one of several source tick streams, counts strobes of that stream, and produces a divided square wave plus a one-cycle tick at the end of every output period. Sources are one-cycle enable strobes in the system clock domain, so the whole block is synchronous to a single clock and no clock switching takes place.

A parameter selects the slice layout. The legacy layout has two sources, a dedicated enable bit and even divisors only. The extended layout has three sources, uses mux code zero as the disable, and adds one bit per word that switches all three of that word's generators to any-integer division. Software writes and reads the control words through a plain write/read port. A changed divisor or source is applied only at an output period boundary, which keeps every output period whole.

Top module: `fgen_bank`

## Requirements
- R1: Word address 0 holds generators 0 to 2 and address 1 holds generators 3 to 5. Generator k of a word uses bits 10k+9 down to 10k. A read returns the last written value with unused bits as zero: bit 31 is always unused, and bit 30 is also unused in the legacy layout.
- R2: In the legacy layout, slice bit 0 picks the source (0 = CPU tick, 1 = auxiliary tick), slice bit 1 enables the generator, and slice bits 9:2 hold N, which gives a divisor of 2*(N+1).
- R3: In the extended layout, slice bits 1:0 are a source code: 0 disables the generator, 1 picks the second auxiliary tick, 2 picks the CPU tick and 3 picks the auxiliary tick.
- R4: In the extended layout, word bit 30 set makes the divisor N+1 for that word's generators. When the bit is clear the divisor is 2*(N+1).
- R5: tick_o pulses for exactly one cycle, in the cycle after the input strobe that completes each period of d selected strobes.
- R6: clk_o is high from the start of each period for floor(d/2) strobes and low for the rest, so it stays low when d = 1.
- R7: A disabled generator holds clk_o low and gives no ticks. Its strobe count restarts, so after it is enabled again the first tick comes after exactly d strobes.
- R8: A divisor or source written during a period takes effect only after that period completes.
- R9: Strobes on sources that are not selected have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_addr_i | input | 1 | Control word write address |
| wr_data_i | input | 32 | Control word write data |
| rd_addr_i | input | 1 | Control word read address |
| rd_data_o | output | 32 | Control word read data |
| cpu_tick_i | input | 1 | CPU-rate source strobe |
| aux_tick_i | input | 1 | Auxiliary source strobe |
| aux2_tick_i | input | 1 | Second auxiliary source strobe (extended layout only) |
| clk_o | output | 6 | Divided clock, one bit per generator |
| tick_o | output | 6 | Period-end tick, one bit per generator |

## Verification
The hardest cases are a divisor rewritten part-way through a period and a generator disabled while its count is non-zero. The stimulus reaches both by writing a word only after a counted number of source strobes. It then shows from the tick positions alone that the old divisor finishes its period and that, after re-enabling, a full period is counted again. The legacy layout gets its own instance, which receives the same strobes, so that an ignored bit 30 is seen to leave the divisor unchanged.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  localparam int unsigned NUM_REG     = 2;
  localparam int unsigned GEN_PER_REG = 3;
  localparam int unsigned NUM_GEN     = NUM_REG * GEN_PER_REG;
  localparam int unsigned SLICE_W     = 10;
  localparam int unsigned DIV_W       = 8;
  localparam int unsigned CNT_W       = DIV_W + 1;
  localparam int unsigned NUM_SRC     = 3;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned SCALE_BIT   = GEN_PER_REG * SLICE_W;
  localparam int unsigned ADDR_W      = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_AUX  = 2'd1,
    SRC_AUX2 = 2'd2
  } src_e;

  typedef struct packed {
    logic             en;
    src_e             src;
    logic [CNT_W-1:0] dm1;  // divisor minus one
  } gen_cfg_t;
endpackage

// File: rtl/fgen_regs.sv
module fgen_regs
  import fgen_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [REG_W-1:0]                wr_data_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  output logic [REG_W-1:0]                rd_data_o,
  output logic [NUM_REG-1:0][REG_W-2:0]   regs_o
);
  localparam int unsigned USED_W = EXTENDED ? SCALE_BIT + 1 : SCALE_BIT;
  localparam logic [REG_W-1:0] USED_MASK = {REG_W{1'b1}} >> (REG_W - USED_W);

  logic [NUM_REG-1:0][REG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
    end else if (wr_en_i) begin
      reg_q[wr_addr_i] <= wr_data_i & USED_MASK;
    end
  end

  assign rd_data_o = reg_q[rd_addr_i];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_out
    assign regs_o[r] = reg_q[r][REG_W-2:0];
  end

  assert_readback_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == rd_addr_i) |=>
      (!$stable(rd_addr_i) || rd_data_o[SCALE_BIT-1:0] == $past(wr_data_i[SCALE_BIT-1:0])))
    else $error("readback mismatch");

  assert_top_bit_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1] == 1'b0)
    else $error("unused bit set");
endmodule

// File: rtl/fgen_dec.sv
module fgen_dec
  import fgen_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic [SLICE_W-1:0] slice_i,
  input  logic               odd_ok_i,
  output gen_cfg_t           cfg_o
);
  logic [DIV_W-1:0] n;
  assign n = slice_i[SLICE_W-1:2];

  always_comb begin
    cfg_o.dm1 = odd_ok_i ? {1'b0, n} : {n, 1'b1};
  end

  if (EXTENDED) begin : g_ext
    always_comb begin
      cfg_o.en = |slice_i[1:0];
      unique case (slice_i[1:0])
        2'd1:    cfg_o.src = SRC_AUX2;
        2'd3:    cfg_o.src = SRC_AUX;
        default: cfg_o.src = SRC_CPU;
      endcase
    end
  end else begin : g_leg
    always_comb begin
      cfg_o.en  = slice_i[1];
      cfg_o.src = slice_i[0] ? SRC_AUX : SRC_CPU;
    end
  end
endmodule

// File: rtl/fgen_div.sv
module fgen_div
  import fgen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  gen_cfg_t           cfg_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic               clk_o,
  output logic               tick_o
);
  logic             idle_q;  // between periods: live config applies
  src_e             act_src_q;
  logic [CNT_W-1:0] act_dm1_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  src_e             eff_src;
  logic [CNT_W-1:0] eff_dm1;
  logic             strobe, last;
  logic [CNT_W:0]   half;

  assign eff_src = idle_q ? cfg_i.src : act_src_q;
  assign eff_dm1 = idle_q ? cfg_i.dm1 : act_dm1_q;

  always_comb begin
    unique case (eff_src)
      SRC_AUX:  strobe = src_tick_i[1];
      SRC_AUX2: strobe = src_tick_i[2];
      default:  strobe = src_tick_i[0];
    endcase
  end

  assign last = (cnt_q == eff_dm1);
  assign half = ({1'b0, eff_dm1} + 1'b1) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q    <= 1'b1;
      act_src_q <= SRC_CPU;
      act_dm1_q <= '0;
      cnt_q     <= '0;
      tick_q    <= 1'b0;
    end else begin
      tick_q <= cfg_i.en & strobe & last;
      if (!cfg_i.en) begin
        cnt_q  <= '0;
        idle_q <= 1'b1;
      end else if (strobe) begin
        if (idle_q) begin
          act_src_q <= cfg_i.src;
          act_dm1_q <= cfg_i.dm1;
        end
        if (last) begin
          cnt_q  <= '0;
          idle_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          idle_q <= 1'b0;
        end
      end
    end
  end

  assign clk_o  = cfg_i.en & ({1'b0, cnt_q} < half);
  assign tick_o = tick_q;

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= eff_dm1)
    else $error("count past divisor");

  assert_off_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> !tick_o)
    else $error("tick while disabled");

  assert_tick_from_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(|src_tick_i))
    else $error("tick without strobe");

  assert_hold_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !idle_q && !strobe) |=> ($stable(act_dm1_q) && $stable(act_src_q)))
    else $error("config changed mid period");
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
  import fgen_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic               cpu_tick_i,
  input  logic               aux_tick_i,
  input  logic               aux2_tick_i,
  output logic [NUM_GEN-1:0] clk_o,
  output logic [NUM_GEN-1:0] tick_o
);
  logic [NUM_REG-1:0][REG_W-2:0] regs;
  logic [NUM_SRC-1:0]            src_ticks;

  assign src_ticks = {aux2_tick_i, aux_tick_i, cpu_tick_i};

  fgen_regs #(.EXTENDED(EXTENDED)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .regs_o    (regs)
  );

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    for (genvar g = 0; g < GEN_PER_REG; g++) begin : g_gen
      localparam int unsigned IDX = r * GEN_PER_REG + g;
      gen_cfg_t cfg;
      logic     odd_ok;

      assign odd_ok = EXTENDED & regs[r][SCALE_BIT];

      fgen_dec #(.EXTENDED(EXTENDED)) u_dec (
        .slice_i  (regs[r][g*SLICE_W +: SLICE_W]),
        .odd_ok_i (odd_ok),
        .cfg_o    (cfg)
      );

      fgen_div u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (cfg),
        .src_tick_i (src_ticks),
        .clk_o      (clk_o[IDX]),
        .tick_o     (tick_o[IDX])
      );
    end
  end
endmodule

// File: tb/fgen_bank_bench.sv
module fgen_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_e = 1'b0, we_l = 1'b0;
  logic [0:0]  wa = '0, ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd_e, rd_l;
  logic        cpu = 1'b0, aux = 1'b0, aux2 = 1'b0;
  logic [5:0]  clk_e, tick_e, clk_l, tick_l;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fgen_bank u_fgen_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we_e), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd_e), .cpu_tick_i(cpu), .aux_tick_i(aux),
    .aux2_tick_i(aux2), .clk_o(clk_e), .tick_o(tick_e));

  fgen_bank #(.EXTENDED(1'b0)) u_fgen_bank_legacy (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we_l), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd_l), .cpu_tick_i(cpu), .aux_tick_i(aux),
    .aux2_tick_i(aux2), .clk_o(clk_l), .tick_o(tick_l));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit ext, logic [0:0] a, logic [31:0] d);
    @(negedge clk);
    wa = a; wd = d;
    if (ext) we_e = 1'b1; else we_l = 1'b1;
    @(negedge clk);
    we_e = 1'b0; we_l = 1'b0;
  endtask

  // mask bit0 cpu, bit1 aux, bit2 aux2; returns one cycle after the edge
  task automatic pulse(logic [2:0] m);
    @(negedge clk);
    {aux2, aux, cpu} = m;
    @(negedge clk);
    {aux2, aux, cpu} = 3'b000;
  endtask

  task automatic t_reset;
    ra = 1'b0; #1;
    chk("R1 reset rd0", rd_e, 32'h0);
    ra = 1'b1; #1;
    chk("R1 reset rd1", rd_e, 32'h0);
    chk("R7 reset clk", {26'd0, clk_e}, 32'h0);
    chk("R5 reset tick", {26'd0, tick_e}, 32'h0);
  endtask

  task automatic t_readback;
    wr(1'b1, 1'b0, 32'hFFFF_FFFF);
    wr(1'b0, 1'b1, 32'hFFFF_FFFF);
    ra = 1'b0; #1;
    chk("R1 ext unused bit31", rd_e, 32'h7FFF_FFFF);
    ra = 1'b1; #1;
    chk("R1 leg unused bits", rd_l, 32'h3FFF_FFFF);
    chk("R1 ext other word", rd_e, 32'h0);
    wr(1'b1, 1'b0, 32'h0);
    wr(1'b0, 1'b1, 32'h0);
    ra = 1'b0; #1;
    chk("R1 cleared", rd_e, 32'h0);
  endtask

  task automatic t_even_scale;  // d=4 from scale set, N=3, cpu
    logic [3:0] ck, tk;
    wr(1'b1, 1'b0, 32'h4000_000E);
    chk("R6 start high", {31'd0, clk_e[0]}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      pulse(3'b110);  // R9 other sources
      chk("R9 unselected strobe", {26'd0, tick_e}, 32'h0);
      pulse(3'b001);
      ck[i] = clk_e[0]; tk[i] = tick_e[0];
    end
    chk("R6 d4 clk sequence", {28'd0, ck}, 32'b1001);
    chk("R5 R4 d4 tick position", {28'd0, tk}, 32'b1000);
    @(negedge clk);
    chk("R5 tick one cycle", {31'd0, tick_e[0]}, 32'd0);
  endtask

  task automatic t_even_noscale;  // scale clear, N=3 -> d=8
    logic [7:0] ck, tk;
    wr(1'b1, 1'b0, 32'h0000_000E);
    for (int i = 0; i < 8; i++) begin
      pulse(3'b001);
      ck[i] = clk_e[0]; tk[i] = tick_e[0];
    end
    chk("R4 d8 clk sequence", {24'd0, ck}, 32'b1000_0111);
    chk("R4 d8 tick position", {24'd0, tk}, 32'b1000_0000);
  endtask

  task automatic t_odd;  // scale set, N=4 -> d=5; then d=1
    logic [4:0] ck, tk;
    wr(1'b1, 1'b0, 32'h4000_0012);
    for (int i = 0; i < 5; i++) begin
      pulse(3'b001);
      ck[i] = clk_e[0]; tk[i] = tick_e[0];
    end
    chk("R6 d5 clk sequence", {27'd0, ck}, 32'b10001);
    chk("R4 d5 tick position", {27'd0, tk}, 32'b10000);
    wr(1'b1, 1'b0, 32'h4000_0002);
    chk("R6 d1 low", {31'd0, clk_e[0]}, 32'd0);
    pulse(3'b001);
    chk("R5 d1 tick", {31'd0, tick_e[0]}, 32'd1);
    chk("R6 d1 stays low", {31'd0, clk_e[0]}, 32'd0);
    pulse(3'b001);
    chk("R5 d1 tick again", {31'd0, tick_e[0]}, 32'd1);
  endtask

  task automatic t_mux;
    wr(1'b1, 1'b0, 32'h4000_0001);  // code 1 -> aux2
    pulse(3'b011);
    chk("R3 code1 ignores cpu/aux", {31'd0, tick_e[0]}, 32'd0);
    pulse(3'b100);
    chk("R3 code1 aux2", {31'd0, tick_e[0]}, 32'd1);
    wr(1'b1, 1'b0, 32'h4000_0003);  // code 3 -> aux
    pulse(3'b100);
    chk("R3 code3 ignores aux2", {31'd0, tick_e[0]}, 32'd0);
    pulse(3'b010);
    chk("R3 code3 aux", {31'd0, tick_e[0]}, 32'd1);
    wr(1'b1, 1'b0, 32'h0);
    wr(1'b1, 1'b1, 32'h4000_0C00);  // gen 4 = word1 bits 19:10, code 3
    pulse(3'b010);
    chk("R1 gen4 placement", {26'd0, tick_e}, 32'b01_0000);
    wr(1'b1, 1'b1, 32'h0);
  endtask

  task automatic t_disable;
    int cnt_t;
    wr(1'b1, 1'b0, 32'h4000_000E);  // d=4
    pulse(3'b001); pulse(3'b001);
    wr(1'b1, 1'b0, 32'h4000_000C);  // code 0
    chk("R7 off low", {31'd0, clk_e[0]}, 32'd0);
    cnt_t = 0;
    for (int i = 0; i < 3; i++) begin
      pulse(3'b001);
      cnt_t += tick_e[0];
    end
    chk("R7 off no ticks", cnt_t, 32'd0);
    wr(1'b1, 1'b0, 32'h4000_000E);
    chk("R7 re-enable high", {31'd0, clk_e[0]}, 32'd1);
    cnt_t = 0;
    for (int i = 0; i < 3; i++) begin
      pulse(3'b001);
      cnt_t += tick_e[0];
    end
    chk("R7 restart no early tick", cnt_t, 32'd0);
    pulse(3'b001);
    chk("R7 restart full period", {31'd0, tick_e[0]}, 32'd1);
  endtask

  task automatic t_midchange;
    logic [4:0] tk;
    pulse(3'b001);                   // d=4 period started, count 1
    wr(1'b1, 1'b0, 32'h4000_0002);   // d=1 requested
    chk("R8 old duty kept", {31'd0, clk_e[0]}, 32'd1);
    for (int i = 0; i < 5; i++) begin
      pulse(3'b001);
      tk[i] = tick_e[0];
    end
    chk("R8 change at boundary", {27'd0, tk}, 32'b11100);
    wr(1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_legacy;
    logic [3:0] ck, tk;
    wr(1'b0, 1'b0, 32'h4000_0007);  // aux, enabled, N=1 -> d=4; bit30 ignored
    ra = 1'b0; #1;
    chk("R1 leg bit30 dropped", rd_l, 32'h0000_0007);
    pulse(3'b101);
    chk("R2 leg ignores cpu", {31'd0, tick_l[0]}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      pulse(3'b010);
      ck[i] = clk_l[0]; tk[i] = tick_l[0];
    end
    chk("R2 leg clk sequence", {28'd0, ck}, 32'b1001);
    chk("R2 leg d4 tick", {28'd0, tk}, 32'b1000);
    wr(1'b0, 1'b0, 32'h0000_0005);  // enable bit clear
    chk("R2 leg disabled low", {31'd0, clk_l[0]}, 32'd0);
    pulse(3'b010);
    chk("R2 leg disabled no tick", {31'd0, tick_l[0]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_even_scale();
    t_even_noscale();
    t_odd();
    t_mux();
    t_disable();
    t_midchange();
    t_legacy();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule